// File: doc/BRIEF.md
# Mode-Banked Register Switch Unit

This unit keeps the mode-dependent shadow copies of a 32-bit core's stack pointer (r13), link register (r14) and saved status word (SPSR). It also keeps a second set of r8 through r12 that only the fast-interrupt mode sees. The live copies of r8 to r14 and of the SPSR sit in the unit. The core reads them through output ports and writes them through a single write port.

To change mode, the core raises a switch strobe together with the requested mode. The exchange completes in one clock. The live stack pointer, link register and SPSR are stored into the outgoing mode's bank and reloaded from the incoming mode's bank. A move into or out of fast-interrupt mode also swaps r8 to r12 between the shared set and the fast-interrupt set. In the following cycle the unit pulses a done flag and shows the new mode. A request for an undefined mode is refused with an error pulse. A request for the mode already in force leaves everything as it is.

Top module: `mb_switch_unit`

## Requirements
- R1: After reset the current mode is supervisor (0x13), every live and banked value is zero, and the done and error flags are low.
- R2: The defined mode codes are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. The current-mode output only ever shows one of these codes.
- R3: A strobe whose requested code is not defined raises the error flag for one cycle in the next cycle, does not raise done, and changes neither the mode nor any register.
- R4: An accepted strobe for a different mode raises done for one cycle in the next cycle, sets the current mode to the requested code, saves the live r13, r14 and SPSR into the old mode's bank and loads them from the new mode's bank.
- R5: When fast-interrupt mode is left, the live r8–r12 go to the fast-interrupt set and are reloaded from the shared set. Switches between two other modes leave r8–r12 untouched.
- R6: When fast-interrupt mode is entered, the live r8–r12 go to the shared set and are reloaded from the fast-interrupt set.
- R7: A strobe for the mode already current raises done and changes no register.
- R8: User and system modes share one bank, so switching between them keeps r13, r14 and the SPSR.
- R9: With the write enable high, the data lands in the live register chosen by the select field at the next edge. Select codes 0–4 address r8–r12, 5 addresses r13, 6 addresses r14 and 7 addresses the SPSR.
- R10: A write issued in the same cycle as an accepted switch belongs to the outgoing mode: its value is saved into the outgoing bank, and the live register then shows the incoming bank's value.
- R11: A write issued in the same cycle as a refused or same-mode strobe updates the live register as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req | input | 1 | Mode switch strobe |
| new_mode | input | 5 | Requested mode code |
| wr_en | input | 1 | Live register write enable |
| wr_sel | input | 3 | Live register select (0–4 r8–r12, 5 r13, 6 r14, 7 SPSR) |
| wr_data | input | 32 | Write data |
| cur_mode | output | 5 | Current mode code |
| sw_done | output | 1 | One-cycle pulse for an accepted strobe |
| bad_mode | output | 1 | One-cycle pulse for a refused strobe |
| live_lo | output | 160 | Live r8–r12, r8 in the lowest 32 bits |
| live_sp | output | 32 | Live r13 |
| live_lr | output | 32 | Live r14 |
| live_spsr | output | 32 | Live SPSR |

## Verification
A core register write and a mode switch can hit the same edge. In that case the written value must end up in the outgoing mode's bank and must not appear live after the switch. The bench writes r13 in the same cycle as a move into interrupt mode, and r9 in the same cycle as a move into fast-interrupt mode. It then switches back and checks that the written values come back. It also pairs a write with a refused strobe and checks that the write takes effect live.

// File: rtl/mb_pkg.sv
package mb_pkg;
   localparam int MODE_W = 5;
   localparam int NBANK  = 6;
   localparam int BANK_W = 3;
   localparam logic [MODE_W-1:0] M_USR = 5'h10;
   localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
   localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
   localparam logic [MODE_W-1:0] M_SVC = 5'h13;
   localparam logic [MODE_W-1:0] M_ABT = 5'h17;
   localparam logic [MODE_W-1:0] M_UND = 5'h1B;
   localparam logic [MODE_W-1:0] M_SYS = 5'h1F;
endpackage

// File: rtl/mb_mode_decode.sv
module mb_mode_decode
   import mb_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   output logic [BANK_W-1:0] bank,
   output logic              valid,
   output logic              is_fiq
);
   always_comb begin
      bank  = '0;
      valid = 1'b1;
      unique case (mode)
         M_USR, M_SYS: bank = 3'd0;
         M_SVC:        bank = 3'd1;
         M_ABT:        bank = 3'd2;
         M_UND:        bank = 3'd3;
         M_IRQ:        bank = 3'd4;
         M_FIQ:        bank = 3'd5;
         default:      valid = 1'b0;
      endcase
      is_fiq = (mode == M_FIQ);
   end
endmodule

// File: rtl/mb_bank_store.sv
module mb_bank_store
   import mb_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_en,
   input  logic [BANK_W-1:0] save_idx,
   input  logic [DW-1:0]     save_sp,
   input  logic [DW-1:0]     save_lr,
   input  logic [DW-1:0]     save_spsr,
   input  logic [BANK_W-1:0] load_idx,
   output logic [DW-1:0]     load_sp,
   output logic [DW-1:0]     load_lr,
   output logic [DW-1:0]     load_spsr
);
   logic [DW-1:0] sp_r   [NBANK];
   logic [DW-1:0] lr_r   [NBANK];
   logic [DW-1:0] spsr_r [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sp_r[b]   <= '0;
            lr_r[b]   <= '0;
            spsr_r[b] <= '0;
         end else if (save_en && save_idx == BANK_W'(b)) begin
            sp_r[b]   <= save_sp;
            lr_r[b]   <= save_lr;
            spsr_r[b] <= save_spsr;
         end
      end
   end

   always_comb begin
      load_sp   = '0;
      load_lr   = '0;
      load_spsr = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (load_idx == BANK_W'(b)) begin
            load_sp   = sp_r[b];
            load_lr   = lr_r[b];
            load_spsr = spsr_r[b];
         end
      end
   end
endmodule

// File: rtl/mb_fiq_store.sv
module mb_fiq_store #(
   parameter int DW  = 32,
   parameter int NLO = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_usr,
   input  logic              save_fiq,
   input  logic [NLO*DW-1:0] save_data,
   output logic [NLO*DW-1:0] usr_q,
   output logic [NLO*DW-1:0] fiq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usr_q <= '0;
         fiq_q <= '0;
      end else begin
         if (save_usr) usr_q <= save_data;
         if (save_fiq) fiq_q <= save_data;
      end
   end
endmodule

// File: rtl/mb_switch_unit.sv
module mb_switch_unit
   import mb_pkg::*;
#(
   parameter int DW  = 32,
   parameter int NLO = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req,
   input  logic [4:0]        new_mode,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DW-1:0]     wr_data,
   output logic [4:0]        cur_mode,
   output logic              sw_done,
   output logic              bad_mode,
   output logic [NLO*DW-1:0] live_lo,
   output logic [DW-1:0]     live_sp,
   output logic [DW-1:0]     live_lr,
   output logic [DW-1:0]     live_spsr
);
   localparam int SEL_SP   = NLO;
   localparam int SEL_LR   = NLO + 1;
   localparam int SEL_SPSR = NLO + 2;

   if (DW < 8)  $error("DW must be at least 8");
   if (NLO != 5) $error("NLO must be 5 so that select codes fit 3 bits");

   logic [BANK_W-1:0] cur_bank, new_bank;
   logic              cur_valid, new_valid, cur_fiq, new_fiq;
   logic [NLO*DW-1:0] eff_lo, usr_lo, fiq_lo;
   logic [DW-1:0]     eff_sp, eff_lr, eff_spsr, ld_sp, ld_lr, ld_spsr;
   logic              accept, same_bank;

   mb_mode_decode u_dec_cur (.mode(cur_mode), .bank(cur_bank), .valid(cur_valid), .is_fiq(cur_fiq));
   mb_mode_decode u_dec_new (.mode(new_mode), .bank(new_bank), .valid(new_valid), .is_fiq(new_fiq));

   // Merge a same-cycle core write before anything is saved.
   for (genvar i = 0; i < NLO; i++) begin : g_eff
      assign eff_lo[i*DW +: DW] = (wr_en && wr_sel == 3'(i)) ? wr_data : live_lo[i*DW +: DW];
   end
   assign eff_sp   = (wr_en && wr_sel == 3'(SEL_SP))   ? wr_data : live_sp;
   assign eff_lr   = (wr_en && wr_sel == 3'(SEL_LR))   ? wr_data : live_lr;
   assign eff_spsr = (wr_en && wr_sel == 3'(SEL_SPSR)) ? wr_data : live_spsr;

   assign accept    = sw_req && new_valid && (new_mode != cur_mode) && cur_valid;
   assign same_bank = (cur_bank == new_bank);

   mb_bank_store #(.DW(DW)) u_banks (
      .clk(clk), .rst_n(rst_n),
      .save_en(accept), .save_idx(cur_bank),
      .save_sp(eff_sp), .save_lr(eff_lr), .save_spsr(eff_spsr),
      .load_idx(new_bank),
      .load_sp(ld_sp), .load_lr(ld_lr), .load_spsr(ld_spsr)
   );

   mb_fiq_store #(.DW(DW), .NLO(NLO)) u_fiq (
      .clk(clk), .rst_n(rst_n),
      .save_usr(accept && new_fiq),
      .save_fiq(accept && cur_fiq),
      .save_data(eff_lo),
      .usr_q(usr_lo), .fiq_q(fiq_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_mode  <= M_SVC;
         sw_done   <= 1'b0;
         bad_mode  <= 1'b0;
         live_lo   <= '0;
         live_sp   <= '0;
         live_lr   <= '0;
         live_spsr <= '0;
      end else begin
         sw_done  <= sw_req && new_valid;
         bad_mode <= sw_req && !new_valid;
         if (accept) begin
            cur_mode  <= new_mode;
            live_sp   <= same_bank ? eff_sp   : ld_sp;
            live_lr   <= same_bank ? eff_lr   : ld_lr;
            live_spsr <= same_bank ? eff_spsr : ld_spsr;
            if (cur_fiq)      live_lo <= usr_lo;
            else if (new_fiq) live_lo <= fiq_lo;
            else              live_lo <= eff_lo;
         end else begin
            live_lo   <= eff_lo;
            live_sp   <= eff_sp;
            live_lr   <= eff_lr;
            live_spsr <= eff_spsr;
         end
      end
   end
endmodule

// File: rtl/mb_switch_chk.sv
module mb_switch_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sw_req,
   input logic [4:0]    new_mode,
   input logic          wr_en,
   input logic [4:0]    cur_mode,
   input logic          sw_done,
   input logic          bad_mode,
   input logic [DW-1:0] live_sp,
   input logic [DW-1:0] live_lr
);
   a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cur_mode inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F});

   a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_done && bad_mode));

   a_r3_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_mode && !$past(wr_en)) |-> ($stable(cur_mode) && $stable(live_sp) && $stable(live_lr)));

   a_r4_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      sw_done |-> ($past(sw_req) && cur_mode == $past(new_mode)));

   a_r7_same_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_done && $stable(cur_mode) && !$past(wr_en)) |-> ($stable(live_sp) && $stable(live_lr)));
endmodule

bind mb_switch_unit mb_switch_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .new_mode(new_mode), .wr_en(wr_en),
   .cur_mode(cur_mode), .sw_done(sw_done), .bad_mode(bad_mode),
   .live_sp(live_sp), .live_lr(live_lr)
);

// File: tb/tb_mb_switch_unit.sv
`timescale 1ns/1ps
module tb_mb_switch_unit;
   localparam int DW = 32;
   localparam int NLO = 5;
   localparam int NV = 14;
   // {requested mode, expected mode afterwards, expected refusal}
   localparam logic [10:0] VEC [NV] = '{
      {5'h17, 5'h17, 1'b0}, {5'h11, 5'h11, 1'b0}, {5'h12, 5'h12, 1'b0},
      {5'h11, 5'h11, 1'b0}, {5'h11, 5'h11, 1'b0}, {5'h1F, 5'h1F, 1'b0},
      {5'h10, 5'h10, 1'b0}, {5'h05, 5'h10, 1'b1}, {5'h1B, 5'h1B, 1'b0},
      {5'h13, 5'h13, 1'b0}, {5'h11, 5'h11, 1'b0}, {5'h10, 5'h10, 1'b0},
      {5'h00, 5'h10, 1'b1}, {5'h14, 5'h10, 1'b1}};

   logic clk = 0, rst_n = 0, sw_req = 0, wr_en = 0;
   logic [4:0] new_mode = 0;
   logic [2:0] wr_sel = 0;
   logic [DW-1:0] wr_data = 0;
   logic [4:0] cur_mode;
   logic sw_done, bad_mode;
   logic [NLO*DW-1:0] live_lo;
   logic [DW-1:0] live_sp, live_lr, live_spsr;

   int n_chk = 0, n_err = 0;
   logic [DW-1:0] m_live [8];
   logic [DW-1:0] m_sp [6], m_lr [6], m_spsr [6], m_usr [5], m_fiq [5];
   logic [4:0] m_cur;

   always #2 clk = ~clk;

   mb_switch_unit #(.DW(DW), .NLO(NLO)) dut (.*);

   function automatic int bank_of(input logic [4:0] m);
      case (m)
         5'h10, 5'h1F: return 0;
         5'h13: return 1;
         5'h17: return 2;
         5'h1B: return 3;
         5'h12: return 4;
         5'h11: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [DW-1:0] live_of(input int i);
      if (i < 5) return live_lo[i*DW +: DW];
      if (i == 5) return live_sp;
      if (i == 6) return live_lr;
      return live_spsr;
   endfunction

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(cur_mode == m_cur, req, DW'(cur_mode), DW'(m_cur));
      for (int i = 0; i < 8; i++) check(live_of(i) === m_live[i], req, live_of(i), m_live[i]);
   endtask

   task automatic mdl_switch(input logic [4:0] m);
      int ob, nb;
      nb = bank_of(m);
      if (nb < 0 || m == m_cur) return;
      ob = bank_of(m_cur);
      if (m_cur == 5'h11) begin
         for (int i = 0; i < 5; i++) begin m_fiq[i] = m_live[i]; m_live[i] = m_usr[i]; end
      end else if (m == 5'h11) begin
         for (int i = 0; i < 5; i++) begin m_usr[i] = m_live[i]; m_live[i] = m_fiq[i]; end
      end
      m_sp[ob] = m_live[5]; m_lr[ob] = m_live[6]; m_spsr[ob] = m_live[7];
      m_live[5] = m_sp[nb]; m_live[6] = m_lr[nb]; m_live[7] = m_spsr[nb];
      m_cur = m;
   endtask

   task automatic do_write(input logic [2:0] sel, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      m_live[sel] = d;
   endtask

   // Switch strobe, optionally with a write in the same cycle.
   task automatic do_sw(input logic [4:0] m, input bit we, input logic [2:0] sel,
                        input logic [DW-1:0] d, input string req);
      bit exp_bad;
      exp_bad = (bank_of(m) < 0);
      @(negedge clk);
      sw_req = 1; new_mode = m; wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk); #1;
      check(sw_done == !exp_bad, req, DW'(sw_done), DW'(!exp_bad));
      check(bad_mode == exp_bad, req, DW'(bad_mode), DW'(exp_bad));
      @(negedge clk);
      sw_req = 0; wr_en = 0;
      if (we) m_live[sel] = d;
      mdl_switch(m);
      check_all(req);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) m_live[i] = '0;
      for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_spsr[i] = '0; end
      for (int i = 0; i < 5; i++) begin m_usr[i] = '0; m_fiq[i] = '0; end
      m_cur = 5'h13;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(sw_done == 0 && bad_mode == 0, "R1", DW'({sw_done, bad_mode}), '0);
      check_all("R1");
      // R9 single write
      do_write(3'd6, 32'hCAFE_0006);
      check(live_lr == 32'hCAFE_0006, "R9", live_lr, 32'hCAFE_0006);
      // Table walk: fresh values in every live register, then the switch
      // (covers R2 R3 R4 R5 R6 R7 R8).
      for (int v = 0; v < NV; v++) begin
         for (int r = 0; r < 8; r++) do_write(3'(r), 32'h1000_0000 | (v << 8) | r);
         do_sw(VEC[v][10:6], 1'b0, 3'd0, '0, "R4");
         check(cur_mode == VEC[v][5:1], VEC[v][0] ? "R3" : "R2", DW'(cur_mode), DW'(VEC[v][5:1]));
      end
      // R8: USR -> SYS keeps r13/r14/SPSR
      do_write(3'd5, 32'h5555_0001);
      do_sw(5'h1F, 1'b0, 3'd0, '0, "R8");
      check(live_sp == 32'h5555_0001, "R8", live_sp, 32'h5555_0001);
      // R10: write r13 together with a switch into IRQ, then come back
      do_sw(5'h12, 1'b1, 3'd5, 32'hABCD_0013, "R10");
      do_sw(5'h1F, 1'b0, 3'd0, '0, "R10");
      check(live_sp == 32'hABCD_0013, "R10", live_sp, 32'hABCD_0013);
      // R10 with r9 on entry to FIQ
      do_sw(5'h11, 1'b1, 3'd1, 32'h9999_0009, "R10");
      do_sw(5'h13, 1'b0, 3'd0, '0, "R5");
      check(live_lo[DW +: DW] == 32'h9999_0009, "R10", live_lo[DW +: DW], 32'h9999_0009);
      // R11: write with refused and with same-mode strobes
      do_sw(5'h02, 1'b1, 3'd6, 32'h1111_0011, "R11");
      check(live_lr == 32'h1111_0011, "R11", live_lr, 32'h1111_0011);
      do_sw(5'h13, 1'b1, 3'd7, 32'h2222_0022, "R11");
      check(live_spsr == 32'h2222_0022, "R11", live_spsr, 32'h2222_0022);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule